// File: doc/BRIEF.md
# Packed Saturating Vector Adder

This block adds two 128-bit operand vectors lane by lane in one cycle. A two-bit width select treats the vectors as sixteen 8-bit lanes, eight 16-bit lanes or four 32-bit lanes. Each lane's add is independent: no carry ever passes from one lane into its neighbour. A saturate enable picks between unsigned clamping and plain modular wrap-around.

A per-lane execute mask decides which lanes write a new value. A lane whose mask bit is clear returns the prior destination value unchanged. That value arrives on its own input, so the unit can merge results into an existing register image. The result, a per-lane overflow flag and a valid flag are registered. They appear one clock after the input strobe.

Top module: `simd_sat_add`

## Requirements
- R1: `laneWidth` 0 selects sixteen 8-bit lanes, 1 selects eight 16-bit lanes, and 2 or 3 select four 32-bit lanes. Lane i occupies bits [i*W +: W] of every vector, and no carry crosses from lane i into lane i+1.
- R2: With `satEn` = 0, each enabled lane returns (a + b) mod 2^W. For example, 250 + 10 in an 8-bit lane gives 4.
- R3: With `satEn` = 1, each enabled lane returns the unsigned sum clamped to 2^W - 1, as if it were computed at double width and narrowed. For example, 250 + 10 in an 8-bit lane gives 255.
- R4: `laneMask` bit i enables lane i. A lane whose bit is clear returns the `priorDst` bits of that lane unchanged. In 16-bit mode mask bits 8 to 15 are ignored, and in 32-bit mode mask bits 4 to 15 are ignored.
- R5: `laneOvf` bit i is 1 exactly when lane i is enabled, `satEn` is 1 and the true sum exceeds 2^W - 1. Bits at or above the lane count are 0, and all bits are 0 in wrap mode.
- R6: `result`, `laneOvf` and `outValid` reflect an operation one clock edge after the edge that samples `inValid` = 1. `outValid` is high for exactly one cycle per accepted operation, including operations issued back to back.
- R7: While `inValid` is 0, `result` and `laneOvf` hold their last values and `outValid` is 0.
- R8: While `rstN` is low, `outValid`, `result` and `laneOvf` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation strobe |
| opA | input | 128 | First operand vector |
| opB | input | 128 | Second operand vector |
| priorDst | input | 128 | Prior destination value, passed through in masked-off lanes |
| laneWidth | input | 2 | Lane width select (0: 8-bit, 1: 16-bit, 2/3: 32-bit) |
| satEn | input | 1 | 1 selects unsigned saturation, 0 selects wrap-around |
| laneMask | input | 16 | Per-lane execute mask |
| outValid | output | 1 | Result valid, one cycle after `inValid` |
| result | output | 128 | Registered result vector |
| laneOvf | output | 16 | Per-lane saturation flag |

## Verification
Every result of this block is due exactly one rising edge after the edge that samples the strobe: `result`, `laneOvf` and `outValid`. The bench drives each operation on a falling edge and drops the strobe on the next falling edge. It reads all three outputs at that point, half a cycle after the single register update. For the hold scenario, it waits several idle cycles and reads the same outputs again. In that scenario it expects `outValid` low and the earlier values unchanged.

// File: rtl/simd_sat_pkg.sv
package simd_sat_pkg;
  localparam int DATA_W = 128;
  localparam int MIN_W  = 8;
  localparam int NUM_B  = DATA_W / MIN_W;
  localparam int NUM_MODES = 3;

  typedef enum logic [1:0] {
    LW8  = 2'd0,
    LW16 = 2'd1,
    LW32 = 2'd2
  } laneMode_e;

  typedef struct packed {
    logic             load;
    logic             sat;
    laneMode_e        mode;
    logic [NUM_B-1:0] laneEn;
    logic [NUM_B-1:0] byteEn;
  } ctrlStrobes_t;
endpackage

// File: rtl/simd_sat_ctrl.sv
module simd_sat_ctrl
  import simd_sat_pkg::*;
(
  input  logic             inValid,
  input  logic [1:0]       laneWidth,
  input  logic             satEn,
  input  logic [NUM_B-1:0] laneMask,
  output ctrlStrobes_t     strobes
);
  laneMode_e mode;
  logic [NUM_B-1:0] laneLimit;
  logic [NUM_B-1:0] byteEn;

  always_comb begin
    case (laneWidth)
      2'd0:    mode = LW8;
      2'd1:    mode = LW16;
      default: mode = LW32;
    endcase
  end

  always_comb begin
    case (mode)
      LW8:     laneLimit = {NUM_B{1'b1}};
      LW16:    laneLimit = NUM_B'((1 << (NUM_B / 2)) - 1);
      default: laneLimit = NUM_B'((1 << (NUM_B / 4)) - 1);
    endcase
  end

  for (genvar i = 0; i < NUM_B; i++) begin : byteGen
    always_comb begin
      case (mode)
        LW8:     byteEn[i] = laneMask[i];
        LW16:    byteEn[i] = laneMask[i / 2];
        default: byteEn[i] = laneMask[i / 4];
      endcase
    end
  end

  always_comb begin
    strobes.load   = inValid;
    strobes.sat    = satEn;
    strobes.mode   = mode;
    strobes.laneEn = laneMask & laneLimit;
    strobes.byteEn = byteEn;
  end
endmodule

// File: rtl/simd_sat_dp.sv
module simd_sat_dp
  import simd_sat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] priorDst,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic [NUM_B-1:0]  laneOvf
);
  for (genvar k = 0; k < NUM_MODES; k++) begin : widthGen
    localparam int W = MIN_W << k;
    localparam int N = DATA_W / W;
    logic [DATA_W-1:0] sumV;
    logic [NUM_B-1:0]  carryV;
    for (genvar l = 0; l < N; l++) begin : laneGen
      logic [W:0] wide;
      assign wide = {1'b0, opA[l*W +: W]} + {1'b0, opB[l*W +: W]};
      assign sumV[l*W +: W] = (strobes.sat && wide[W]) ? {W{1'b1}} : wide[W-1:0];
      assign carryV[l] = wide[W];
    end
    if (N < NUM_B) begin : padGen
      assign carryV[NUM_B-1:N] = '0;
    end
  end

  logic [DATA_W-1:0] modeSum;
  logic [NUM_B-1:0]  modeCarry;
  logic [DATA_W-1:0] mergedRes;
  logic [NUM_B-1:0]  ovfNext;

  always_comb begin
    case (strobes.mode)
      LW8: begin
        modeSum   = widthGen[0].sumV;
        modeCarry = widthGen[0].carryV;
      end
      LW16: begin
        modeSum   = widthGen[1].sumV;
        modeCarry = widthGen[1].carryV;
      end
      default: begin
        modeSum   = widthGen[2].sumV;
        modeCarry = widthGen[2].carryV;
      end
    endcase
  end

  for (genvar i = 0; i < NUM_B; i++) begin : mergeGen
    assign mergedRes[i*MIN_W +: MIN_W] = strobes.byteEn[i] ? modeSum[i*MIN_W +: MIN_W]
                                                          : priorDst[i*MIN_W +: MIN_W];
  end

  assign ovfNext = modeCarry & strobes.laneEn & {NUM_B{strobes.sat}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      result   <= '0;
      laneOvf  <= '0;
    end else begin
      outValid <= strobes.load;
      if (strobes.load) begin
        result  <= mergedRes;
        laneOvf <= ovfNext;
      end
    end
  end

  // R4: a fully masked operation returns the prior destination untouched
  a_r4_mask_pass: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.load && strobes.byteEn == '0) |-> result == $past(priorDst));

  // R2: wrap mode never raises an overflow flag
  a_r2_wrap_no_flag: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.load && !strobes.sat) |-> laneOvf == '0);

  // R5: no flag above the 32-bit lane count
  a_r5_ovf_range: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.load && strobes.mode == LW32) |-> laneOvf[NUM_B-1:DATA_W/32] == '0);

  for (genvar i = 0; i < NUM_B; i++) begin : satChkGen
    // R3: a saturated 8-bit lane is never below its first operand
    a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
      $past(strobes.load && strobes.sat && strobes.mode == LW8 && strobes.byteEn[i])
        |-> result[i*MIN_W +: MIN_W] >= $past(opA[i*MIN_W +: MIN_W]));
  end
endmodule

// File: rtl/simd_sat_add.sv
module simd_sat_add
  import simd_sat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] priorDst,
  input  logic [1:0]        laneWidth,
  input  logic              satEn,
  input  logic [NUM_B-1:0]  laneMask,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic [NUM_B-1:0]  laneOvf
);
  ctrlStrobes_t strobes;

  simd_sat_ctrl ctrlInst (
    .inValid   (inValid),
    .laneWidth (laneWidth),
    .satEn     (satEn),
    .laneMask  (laneMask),
    .strobes   (strobes)
  );

  simd_sat_dp dpInst (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .opA      (opA),
    .opB      (opB),
    .priorDst (priorDst),
    .outValid (outValid),
    .result   (result),
    .laneOvf  (laneOvf)
  );

  // R6: valid follows the strobe by exactly one cycle
  a_r6_valid_latency: assert property (@(posedge clk) disable iff (!rstN)
    outValid == $past(inValid));

  // R7: outputs hold while idle
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(result) && $stable(laneOvf));
endmodule

// File: tb/simd_sat_add_test.sv
`timescale 1ns/1ps
module simd_sat_add_test;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [127:0] opA = '0, opB = '0, priorDst = '0;
  logic [1:0]   laneWidth = 2'd0;
  logic         satEn = 1'b0;
  logic [15:0]  laneMask = '0;
  logic         outValid;
  logic [127:0] result;
  logic [15:0]  laneOvf;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  simd_sat_add uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .priorDst(priorDst), .laneWidth(laneWidth), .satEn(satEn),
    .laneMask(laneMask), .outValid(outValid), .result(result), .laneOvf(laneOvf)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model(input logic [127:0] a, input logic [127:0] b, input logic [127:0] p,
                       input logic [1:0] wsel, input logic sat, input logic [15:0] m,
                       output logic [127:0] r, output logic [15:0] o);
    int w;
    logic [63:0] mw;
    w = (wsel == 2'd0) ? 8 : (wsel == 2'd1) ? 16 : 32;
    mw = (64'd1 << w) - 64'd1;
    r = '0;
    o = '0;
    for (int l = 0; l < 128 / w; l++) begin
      logic [63:0] av, bv, pv, sv, v;
      av = 64'(a >> (l * w)) & mw;
      bv = 64'(b >> (l * w)) & mw;
      pv = 64'(p >> (l * w)) & mw;
      sv = av + bv;
      if (m[l]) begin
        if (sat && sv > mw) begin
          v = mw;
          o[l] = 1'b1;
        end else v = sv & mw;
      end else v = pv;
      r = r | (128'(v) << (l * w));
    end
  endtask

  // drive one operation, then check all outputs one edge later
  task automatic runOp(input string req, input logic [127:0] a, input logic [127:0] b,
                       input logic [127:0] p, input logic [1:0] wsel, input logic sat,
                       input logic [15:0] m);
    logic [127:0] er;
    logic [15:0]  eo;
    model(a, b, p, wsel, sat, m, er, eo);
    @(negedge clk);
    opA = a; opB = b; priorDst = p; laneWidth = wsel; satEn = sat; laneMask = m;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check({req, " result"}, result, er);
    check({req, " ovf"}, 128'(laneOvf), 128'(eo));
    check("R6 valid", 128'(outValid), 128'd1);
  endtask

  task automatic testReset();
    check("R8 reset valid", 128'(outValid), 128'd0);
    check("R8 reset result", result, 128'd0);
    check("R8 reset ovf", 128'(laneOvf), 128'd0);
  endtask

  task automatic testWrap8();
    runOp("R2 wrap8", {16{8'd250}}, {16{8'd10}}, '0, 2'd0, 1'b0, 16'hFFFF);
    check("R2 literal 250+10", 128'(result[7:0]), 128'd4);
  endtask

  task automatic testSat8();
    runOp("R3 sat8", {16{8'd250}}, {16{8'd10}}, '0, 2'd0, 1'b1, 16'hFFFF);
    check("R3 literal clamp", 128'(result[7:0]), 128'd255);
    check("R5 all flags", 128'(laneOvf), 128'hFFFF);
    runOp("R3 sat8 mix", {8{8'd1, 8'd200}}, {8{8'd2, 8'd100}}, '0, 2'd0, 1'b1, 16'hFFFF);
  endtask

  task automatic testIsolation();
    // R1: lane 0 overflows, lane 1 must stay 0
    runOp("R1 iso16", {{112{1'b0}}, 16'hFFFF}, 128'd1, '0, 2'd1, 1'b0, 16'h00FF);
    check("R1 no carry 16", 128'(result[31:16]), 128'd0);
    runOp("R1 iso32", {{96{1'b0}}, 32'hFFFFFFFF}, 128'd1, '0, 2'd2, 1'b0, 16'h000F);
    check("R1 no carry 32", 128'(result[63:32]), 128'd0);
    runOp("R1 iso8", {{120{1'b0}}, 8'hFF}, 128'd1, '0, 2'd0, 1'b0, 16'hFFFF);
    check("R1 no carry 8", 128'(result[15:8]), 128'd0);
  endtask

  task automatic testSatWide();
    runOp("R3 sat16", {8{16'hFFF0}}, {4{16'h0001, 16'h0020}}, '0, 2'd1, 1'b1, 16'h00FF);
    runOp("R3 sat32 mode3", {4{32'hF0000000}}, {2{32'h0FFFFFFF, 32'h20000000}}, '0, 2'd3, 1'b1, 16'h000F);
    check("R5 ovf32 pattern", 128'(laneOvf), 128'h5);
  endtask

  task automatic testMask();
    logic [127:0] pr;
    pr = {4{32'hDEADBEEF}};
    runOp("R4 mask8", {16{8'h11}}, {16{8'h22}}, pr, 2'd0, 1'b0, 16'hA5C3);
    runOp("R4 mask16 hi ignored", {8{16'h1234}}, {8{16'h1111}}, pr, 2'd1, 1'b1, 16'hFF0A);
    runOp("R4 mask32 hi ignored", {4{32'hFFFFFFFF}}, {4{32'h2}}, pr, 2'd2, 1'b1, 16'hFFF2);
    check("R5 masked flags only", 128'(laneOvf), 128'h2);
    runOp("R4 mask none", {16{8'hFF}}, {16{8'hFF}}, pr, 2'd0, 1'b1, 16'h0000);
    check("R4 pass prior", result, pr);
  endtask

  task automatic testHold();
    logic [127:0] keepR;
    logic [15:0]  keepO;
    runOp("R7 setup", {16{8'hF0}}, {16{8'h20}}, '0, 2'd0, 1'b1, 16'h0F0F);
    keepR = result;
    keepO = laneOvf;
    opA = '1; opB = '1; laneMask = '1;
    repeat (4) @(negedge clk);
    check("R7 valid low", 128'(outValid), 128'd0);
    check("R7 result held", result, keepR);
    check("R7 ovf held", 128'(laneOvf), 128'(keepO));
  endtask

  task automatic testBackToBack();
    logic [127:0] r1, r2;
    logic [15:0]  o1, o2;
    model({16{8'h80}}, {16{8'h80}}, '0, 2'd0, 1'b1, 16'hFFFF, r1, o1);
    model({8{16'h0102}}, {8{16'h0304}}, '0, 2'd1, 1'b0, 16'h00FF, r2, o2);
    @(negedge clk);
    opA = {16{8'h80}}; opB = {16{8'h80}}; priorDst = '0; laneWidth = 2'd0;
    satEn = 1'b1; laneMask = 16'hFFFF; inValid = 1'b1;
    @(negedge clk);
    check("R6 b2b first", result, r1);
    check("R6 b2b first valid", 128'(outValid), 128'd1);
    opA = {8{16'h0102}}; opB = {8{16'h0304}}; laneWidth = 2'd1; satEn = 1'b0; laneMask = 16'h00FF;
    @(negedge clk);
    inValid = 1'b0;
    check("R6 b2b second", result, r2);
    check("R6 b2b second valid", 128'(outValid), 128'd1);
    check("R5 b2b wrap flags", 128'(laneOvf), 128'(o2));
    @(negedge clk);
    check("R6 valid drops", 128'(outValid), 128'd0);
  endtask

  task automatic testRandom();
    for (int n = 0; n < 24; n++) begin
      logic [127:0] a, b, p;
      a = {$urandom, $urandom, $urandom, $urandom};
      b = {$urandom, $urandom, $urandom, $urandom};
      p = {$urandom, $urandom, $urandom, $urandom};
      runOp("R1 R2 R3 R4 random", a, b, p, 2'(n % 4), 1'(n / 4 % 2), 16'($urandom));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testWrap8();
    testSat8();
    testIsolation();
    testSatWide();
    testMask();
    testHold();
    testBackToBack();
    testRandom();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule